// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a 4-bit binary address into one of 16 active-high select lines. A hold stage sits in front of the decode. While the load control `latch_en` is high, the stage passes the live address straight through. When `latch_en` falls, the stage keeps the last address it saw, and the selected line stays put whatever the address bus does afterwards. The active-low output enable `out_en_n` acts only on the 16 lines and never touches the stored address.

Because the enable gates only the outputs, the block also works as a 1-to-16 demultiplexer. The serial data bit is applied to `out_en_n`, and the address picks which line receives it. The chosen line carries the inverse of the data level and the other lines stay low.

The parameter `HOLD_STYLE` picks how the hold stage is built. Style 0 (clocked) samples the address on every rising `clk` edge while `latch_en` is high and passes the live address through a bypass mux. Style 1 (latch) uses a level-sensitive latch. Both styles run a two-state tracker clocked by `clk`. State `ST_PASS` means `latch_en` was high at the last edge. State `ST_FROZEN` means it was low. The tracker moves from `ST_PASS` to `ST_FROZEN` on the transition *freeze*, which is an edge that sees `latch_en` low. It moves from `ST_FROZEN` to `ST_PASS` on the transition *open*, which is an edge that sees `latch_en` high. Otherwise it stays where it is. Reset puts the tracker in `ST_PASS`.

Top module: `latched_line_decoder`

## Requirements
- R1: Address bit 0 is the least significant bit. When enabled, line i is high only when the address value equals i, for i from 0 to 15.
- R2: While `latch_en` is high, the lines follow the live `addr` input in the same cycle, with no clock latency.
- R3: After `latch_en` goes low, the lines keep showing the address that was present while `latch_en` was last high. Later changes on `addr` have no effect. In clocked style that address must be held steady across the last rising edge with `latch_en` high.
- R4: At most one line is high at any time. Exactly one line is high whenever `out_en_n` is 0.
- R5: When `out_en_n` is 1, all 16 lines are 0, whatever address is stored.
- R6: `out_en_n` never alters the stored address. The address is still captured while `out_en_n` is 1, and toggling `out_en_n` during a hold leaves the stored address unchanged.
- R7: In demultiplexer use, the line selected by the address equals the inverse of `out_en_n` and every other line is 0.
- R8: An active-low `rst_n` clears the stored address to 0 and puts the tracker in `ST_PASS`. With `latch_en` low and `out_en_n` 0, line 0 is high during and after reset.
- R9: Both values of `HOLD_STYLE` (0 clocked, 1 latch) give the same line values for inputs changed away from the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the clocked hold style and for the state tracker |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored address |
| addr | input | 4 | Binary address, bit 0 least significant |
| latch_en | input | 1 | High: address passes through. Low: stored address is held |
| out_en_n | input | 1 | Active-low output enable; demultiplexer data input |
| lines | output | 16 | One-hot active-high select lines |

## Verification
Every line value is due in the same cycle as the input that causes it, because the decode and the gating are combinational after the hold stage. The one exception is the stored address in clocked style, which is taken at the rising edge before `latch_en` is seen low. The bench drives inputs on the falling edge and pushes the expected line word into a queue. A monitor pops and compares that word 3 ns later, still before the next rising edge, for both hold styles at once. The same monitor checks the one-hot rules on every cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic {
        ST_PASS   = 1'b0,
        ST_FROZEN = 1'b1
    } hold_state_t;

    localparam int STYLE_CLOCKED = 0;
    localparam int STYLE_LATCH   = 1;
endpackage

// File: rtl/addr_hold.sv
module addr_hold
    import dec_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int HOLD_STYLE = STYLE_CLOCKED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              latch_en,
    output logic [ADDR_W-1:0] sel
);
    hold_state_t state;

    // State register: open (to ST_PASS) or freeze (to ST_FROZEN)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            unique case (state)
                ST_PASS:   state <= latch_en ? ST_PASS : ST_FROZEN;
                ST_FROZEN: state <= latch_en ? ST_PASS : ST_FROZEN;
                default:   state <= ST_PASS;
            endcase
        end
    end

    generate
        if (HOLD_STYLE == STYLE_LATCH) begin : g_latch
            logic [ADDR_W-1:0] held;
            always_latch begin
                if (!rst_n)        held = '0;
                else if (latch_en) held = addr;
            end
            assign sel = held;
        end else begin : g_clocked
            logic [ADDR_W-1:0] held_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        held_q <= '0;
                else if (latch_en) held_q <= addr;
            end
            // Output process: live bypass while open, stored value otherwise
            always_comb begin
                if (latch_en) sel = addr;
                else          sel = held_q;
            end
        end
    endgenerate

    // R3 / R6: once frozen and still closed, the selection cannot move
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !latch_en) |-> (sel == $past(sel)));
endmodule

// File: rtl/line_decode.sv
module line_decode #(
    parameter int ADDR_W = 4,
    localparam int LINES = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [LINES-1:0]  onehot
);
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            assign onehot[i] = (sel == ADDR_W'(i));
        end
    endgenerate
endmodule

// File: rtl/line_gate.sv
module line_gate #(
    parameter int LINES = 16
) (
    input  logic [LINES-1:0] onehot,
    input  logic             out_en_n,
    output logic [LINES-1:0] lines
);
    assign lines = out_en_n ? '0 : onehot;
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
    import dec_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int HOLD_STYLE = STYLE_CLOCKED,
    localparam int LINES     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              latch_en,
    input  logic              out_en_n,
    output logic [LINES-1:0]  lines
);
    logic [ADDR_W-1:0] sel;
    logic [LINES-1:0]  onehot;

    addr_hold #(.ADDR_W(ADDR_W), .HOLD_STYLE(HOLD_STYLE)) u_hold (
        .clk(clk), .rst_n(rst_n), .addr(addr), .latch_en(latch_en), .sel(sel)
    );

    line_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel(sel), .onehot(onehot)
    );

    line_gate #(.LINES(LINES)) u_gate (
        .onehot(onehot), .out_en_n(out_en_n), .lines(lines)
    );

    assert_at_most_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lines));
    assert_exactly_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> ($countones(lines) == 1));
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (lines == '0));
    assert_demux_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lines[sel] == !out_en_n);
endmodule

// File: tb/latched_line_decoder_test.sv
module latched_line_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        latch_en;
    logic        out_en_n;
    logic [15:0] q_clk;
    logic [15:0] q_lat;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    latched_line_decoder #(.HOLD_STYLE(0)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .latch_en(latch_en),
        .out_en_n(out_en_n), .lines(q_clk)
    );

    latched_line_decoder #(.HOLD_STYLE(1)) uut_latch (
        .clk(clk), .rst_n(rst_n), .addr(addr), .latch_en(latch_en),
        .out_en_n(out_en_n), .lines(q_lat)
    );

    function automatic logic [15:0] hot(input logic [3:0] a);
        return 16'h0001 << a;
    endfunction

    task automatic compare(input string req, input string tag,
                           input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): lines=%h expected %h", req, tag, act, exp);
        end
    endtask

    // Driver: apply on falling edge, queue the expected line word
    task automatic drive(input logic [3:0] a, input logic le, input logic en_n,
                         input logic [15:0] exp, input string req);
        @(negedge clk);
        addr     = a;
        latch_en = le;
        out_en_n = en_n;
        sb.push_back('{exp, req});
    endtask

    // Monitor: compare 3 ns after the falling edge, away from the rising edge
    always @(negedge clk) begin
        item_t it;
        #3;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            compare(it.req, "clocked", q_clk, it.exp);
            compare({it.req, "/R9"}, "latch", q_lat, it.exp);
        end
        if (rst_n === 1'b1) begin
            n_vec++;
            if ($countones(q_clk) > 1 || $countones(q_lat) > 1 ||
                (!out_en_n && ($countones(q_clk) != 1 || $countones(q_lat) != 1))) begin
                n_bad++;
                $display("FAIL R4: one-hot rule, lines=%h/%h expected one hot (en_n=%b)",
                         q_clk, q_lat, out_en_n);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        addr     = 4'd9;
        latch_en = 1'b0;
        out_en_n = 1'b0;
        // R8: reset clears stored address, line 0 shows
        drive(4'd9, 1'b0, 1'b0, 16'h0001, "R8");
        drive(4'd9, 1'b0, 1'b0, 16'h0001, "R8");
        @(negedge clk);
        rst_n = 1'b1;
        sb.push_back('{16'h0001, "R8"});
        // R1 / R2: sweep every address while open
        for (int a = 0; a < 16; a++) begin
            drive(4'(a), 1'b1, 1'b0, hot(4'(a)), "R1");
        end
        drive(4'd5, 1'b1, 1'b0, hot(4'd5), "R2");
        // R3: close with 5 captured, move the bus
        drive(4'd12, 1'b0, 1'b0, hot(4'd5), "R3");
        drive(4'd0,  1'b0, 1'b0, hot(4'd5), "R3");
        drive(4'd15, 1'b0, 1'b0, hot(4'd5), "R3");
        // R5 / R6: toggle enable during the hold
        drive(4'd7, 1'b0, 1'b1, 16'h0000, "R5");
        drive(4'd2, 1'b0, 1'b0, hot(4'd5), "R6");
        drive(4'd9, 1'b0, 1'b1, 16'h0000, "R5");
        drive(4'd9, 1'b0, 1'b0, hot(4'd5), "R6");
        // R6: capture still happens while outputs are disabled
        drive(4'd10, 1'b1, 1'b1, 16'h0000, "R5");
        drive(4'd4,  1'b0, 1'b0, hot(4'd10), "R6");
        // R2: reopen follows the live address at once
        drive(4'd6, 1'b1, 1'b0, hot(4'd6), "R2");
        // R7: demultiplex a data stream onto line 3
        drive(4'd3, 1'b1, 1'b1, 16'h0000, "R7");
        drive(4'd3, 1'b1, 1'b0, 16'h0008, "R7");
        drive(4'd3, 1'b1, 1'b1, 16'h0000, "R7");
        drive(4'd3, 1'b1, 1'b0, 16'h0008, "R7");
        // R7 while held on line 3, bus elsewhere
        drive(4'd14, 1'b0, 1'b1, 16'h0000, "R7");
        drive(4'd14, 1'b0, 1'b0, 16'h0008, "R7");
        repeat (3) @(negedge clk);
        #5;
        finish_run();
    end
endmodule